// File: doc/BRIEF.md
# Reconfigurable Region Freeze Controller

This block isolates a reconfigurable logic region from the static logic around it. Software drives it through four 32-bit word registers on a simple register bus. A write to the control word asks the block to freeze the region or to release it, and a read of the status word shows when the request has finished. While the region is frozen, software may also hold the region in reset. The freeze output stays asserted for the whole time the region is isolated. It gates traffic into and out of the region.

A freeze request raises the freeze output at once. It then waits a drain interval, set by a parameter, so that traffic already in flight can leave; after that the status flips to frozen. A release request first drops the region reset. The freeze output stays up for a settle interval, also set by a parameter, and then the freeze output and the status return to the open condition. The block rejects any request that does not fit the current condition. It records the reason in a sticky violation word, which software clears by writing to it. A read-only identifier word lets software check which revision of the block it is talking to.

Byte offsets: 0 status, 4 control, 8 violation, 12 identifier. Reads return data one cycle after the read strobe.

Top module: `frz_bridge_ctl`

## Requirements
- R1: After reset, status reads 2 (bit 1 open-done set, bit 0 frozen-done clear). The freeze output and the region reset are low, and the control and violation words read 0.
- R2: The read at offset 12 returns the identifier parameter (default 2). Every address other than 0, 4, 8 and 12 reads 0. Read data appears in the cycle after the read strobe.
- R3: A control write with bit 0 set (freeze), accepted while open, raises the freeze output in the next cycle. Status stays 2 for DRAIN_CYCLES cycles and then becomes 1.
- R4: While frozen, a control word with bit 1 (reset) set drives the region reset high. The region reset is never high unless the region is fully frozen.
- R5: A control write with bit 2 (release), accepted while frozen, drops the region reset in the next cycle. The freeze output stays high for SETTLE_CYCLES cycles, and then it falls and status becomes 2 in the same cycle.
- R6: Status always has exactly one of its two done bits set.
- R7: A control write that sets bits 0 and 2 together sets violation bit 0 and has no other effect.
- R8: A freeze request when not fully open, or a release request when not fully frozen, sets violation bit 1 and has no effect. This includes requests made during the drain or settle intervals.
- R9: A control write with bit 1 set while not fully frozen sets violation bit 2 and has no effect.
- R10: Violation bits are sticky. A write to offset 8 with data bit 0 set clears them all, and any other write leaves them unchanged.
- R11: Writes to offsets 0 and 12 change nothing.
- R12: The control word reads back the low three bits of the last accepted control write, and a rejected write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| region_freeze | output | 1 | High while the region is isolated |
| region_reset | output | 1 | Reset to the region, only while frozen |

## Verification
The assertions assume that at most one bus access happens per cycle, and that address and write data are known whenever the write strobe is high. Any rise of the freeze output is therefore attributed to the control write of the previous cycle. The bench drives each access for exactly one cycle from tasks and leaves both strobes low between accesses. It sweeps all eight control values from the open condition and from the frozen condition, starting each trial from a fresh reset so that every expectation follows from the requirements alone.

// File: rtl/frz_pkg.sv
package frz_pkg;
  typedef enum logic [1:0] {
    ST_OPEN   = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_HELD   = 2'd2,
    ST_SETTLE = 2'd3
  } frz_state_e;

  localparam int OFS_STATUS  = 0;
  localparam int OFS_CTRL    = 4;
  localparam int OFS_VIOL    = 8;
  localparam int OFS_IDENT   = 12;

  localparam int CB_FREEZE   = 0;
  localparam int CB_RESET    = 1;
  localparam int CB_RELEASE  = 2;
  localparam int CTRL_W      = 3;

  localparam int VB_BOTH     = 0;
  localparam int VB_STATE    = 1;
  localparam int VB_RESET    = 2;
  localparam int VIOL_W      = 3;

  localparam int SB_FROZEN   = 0;
  localparam int SB_OPEN     = 1;
endpackage

// File: rtl/frz_seq.sv
module frz_seq
  import frz_pkg::*;
#(
  parameter int DRAIN_CYCLES  = 16,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_freeze,
  input  logic       go_release,
  input  logic       reset_bit,
  output frz_state_e state,
  output logic [1:0] status,
  output logic       freeze_o,
  output logic       region_rst_o
);
  localparam int MAXC  = (DRAIN_CYCLES > SETTLE_CYCLES) ? DRAIN_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DRAIN_LOAD  = CNT_W'(DRAIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  frz_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_OPEN: begin
          if (go_freeze) begin
            state_q <= ST_DRAIN;
            cnt_q   <= DRAIN_LOAD;
          end
        end
        ST_DRAIN: begin
          if (cnt_zero) state_q <= ST_HELD;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_HELD: begin
          if (go_release) begin
            state_q <= ST_SETTLE;
            cnt_q   <= SETTLE_LOAD;
          end
        end
        ST_SETTLE: begin
          if (cnt_zero) state_q <= ST_OPEN;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_OPEN;
      endcase
    end
  end

  assign state = state_q;

  always_comb begin
    status = '0;
    status[SB_FROZEN] = (state_q == ST_HELD) || (state_q == ST_SETTLE);
    status[SB_OPEN]   = (state_q == ST_OPEN) || (state_q == ST_DRAIN);
  end

  assign freeze_o     = (state_q != ST_OPEN);
  assign region_rst_o = reset_bit && (state_q == ST_HELD);
endmodule

// File: rtl/frz_regs.sv
module frz_regs
  import frz_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter logic [31:0] IDENT   = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  frz_state_e        state,
  input  logic [1:0]        status,
  output logic              go_freeze,
  output logic              go_release,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [VIOL_W-1:0] viol_q
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_VIOL   = ADDR_W'(OFS_VIOL);
  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFS_IDENT);

  logic              ctrl_wr;
  logic              viol_wr;
  logic              want_frz;
  logic              want_rst;
  logic              want_rel;
  logic [VIOL_W-1:0] viol_now;
  logic              accept;

  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign viol_wr  = wr_en && (addr == A_VIOL);
  assign want_frz = wr_data[CB_FREEZE];
  assign want_rst = wr_data[CB_RESET];
  assign want_rel = wr_data[CB_RELEASE];

  always_comb begin
    viol_now = '0;
    viol_now[VB_BOTH]  = want_frz && want_rel;
    viol_now[VB_STATE] = (want_frz && (state != ST_OPEN)) ||
                         (want_rel && (state != ST_HELD));
    viol_now[VB_RESET] = want_rst && (state != ST_HELD);
  end

  assign accept     = ctrl_wr && (viol_now == '0);
  assign go_freeze  = accept && want_frz;
  assign go_release = accept && want_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      viol_q <= '0;
    end else begin
      if (accept) ctrl_q <= wr_data[CTRL_W-1:0];
      if (ctrl_wr)
        viol_q <= viol_q | viol_now;
      else if (viol_wr && wr_data[0])
        viol_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        A_STATUS: rd_data <= {30'd0, status};
        A_CTRL:   rd_data <= {{(32-CTRL_W){1'b0}}, ctrl_q};
        A_VIOL:   rd_data <= {{(32-VIOL_W){1'b0}}, viol_q};
        A_IDENT:  rd_data <= IDENT;
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/frz_bridge_ctl.sv
module frz_bridge_ctl
  import frz_pkg::*;
#(
  parameter int          ADDR_W        = 4,
  parameter int          DRAIN_CYCLES  = 16,
  parameter int          SETTLE_CYCLES = 4,
  parameter logic [31:0] IDENT         = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              region_freeze,
  output logic              region_reset
);
  frz_state_e        state_w;
  logic [1:0]        status_w;
  logic              go_freeze_w;
  logic              go_release_w;
  logic [CTRL_W-1:0] ctrl_w;
  logic [VIOL_W-1:0] viol_w;

  frz_regs #(
    .ADDR_W (ADDR_W),
    .IDENT  (IDENT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .wr_en      (bus_wr),
    .wr_data    (bus_wdata),
    .rd_en      (bus_rd),
    .rd_data    (bus_rdata),
    .state      (state_w),
    .status     (status_w),
    .go_freeze  (go_freeze_w),
    .go_release (go_release_w),
    .ctrl_q     (ctrl_w),
    .viol_q     (viol_w)
  );

  frz_seq #(
    .DRAIN_CYCLES  (DRAIN_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_freeze    (go_freeze_w),
    .go_release   (go_release_w),
    .reset_bit    (ctrl_w[CB_RESET]),
    .state        (state_w),
    .status       (status_w),
    .freeze_o     (region_freeze),
    .region_rst_o (region_reset)
  );
endmodule

// File: rtl/frz_bridge_chk.sv
module frz_bridge_chk
  import frz_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              region_freeze,
  input logic              region_reset,
  input logic [1:0]        status,
  input logic [VIOL_W-1:0] viol
);
  logic ctrl_wr;
  logic viol_wr;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign viol_wr = bus_wr && (bus_addr == ADDR_W'(OFS_VIOL));

  // R6
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status) == 1);

  // R3
  freeze_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(region_freeze) |-> $past(ctrl_wr && bus_wdata[CB_FREEZE]));

  // R4
  reset_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_reset |-> (region_freeze && status[SB_FROZEN]));

  // R7
  both_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[CB_FREEZE] && bus_wdata[CB_RELEASE]) |=> viol[VB_BOTH]);

  // R9
  reset_open_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[CB_RESET] && status[SB_OPEN]) |=> viol[VB_RESET]);

  // R10
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_wr |=> ((viol & $past(viol)) == $past(viol)));
endmodule

bind frz_bridge_ctl frz_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .region_freeze (region_freeze),
  .region_reset  (region_reset),
  .status        (status_w),
  .viol          (viol_w)
);

// File: tb/frz_bridge_ctl_test.sv
module frz_bridge_ctl_test;
  localparam int          AW     = 4;
  localparam int          DRAIN  = 5;
  localparam int          SETTLE = 3;
  localparam logic [31:0] IDV    = 32'h0000_0002;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic          rd = 1'b0;
  logic [31:0]   rdata;
  logic          frz;
  logic          rrst;

  int nvec = 0;
  int nbad = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  frz_bridge_ctl #(
    .ADDR_W(AW), .DRAIN_CYCLES(DRAIN), .SETTLE_CYCLES(SETTLE), .IDENT(IDV)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .region_freeze(frz), .region_reset(rrst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr = 1'b1;
    @(posedge clk);
    #1;
    wr = 1'b0;
  endtask

  task automatic do_read(input int a);
    @(negedge clk);
    addr = AW'(a); rd = 1'b1;
    @(posedge clk);
    #1;
    got = rdata;
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 freeze", {31'd0, frz}, 0);
    check("R1 region reset", {31'd0, rrst}, 0);
    do_read(0);  check("R1 status", got, 2);
    do_read(4);  check("R1 ctrl", got, 0);
    do_read(8);  check("R1 viol", got, 0);

    // R2 identifier and unmapped sweep
    do_read(12); check("R2 ident", got, IDV);
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12) begin
        do_read(a); check("R2 unmapped", got, 0);
      end
    end

    // R11 writes to status and identifier
    do_write(0, 32'hFFFF_FFFF);
    do_write(12, 32'h0);
    do_read(0);  check("R11 status", got, 2);
    do_read(12); check("R11 ident", got, IDV);
    check("R11 freeze", {31'd0, frz}, 0);

    // R3 freeze timing
    do_write(4, 1);
    check("R3 freeze rise", {31'd0, frz}, 1);
    begin
      int k;
      k = 0;
      got = 2;
      while (got != 1 && k < 40) begin
        k++;
        do_read(0);
      end
      check("R3 drain length", k, DRAIN + 1);
    end

    // R4 reset while frozen
    do_write(4, 2);
    check("R4 region reset", {31'd0, rrst}, 1);
    do_read(4); check("R12 ctrl", got, 2);

    // R5 release timing
    do_write(4, 4);
    check("R5 reset drop", {31'd0, rrst}, 0);
    check("R5 freeze held", {31'd0, frz}, 1);
    begin
      int k;
      k = 0;
      got = 1;
      while (got != 2 && k < 40) begin
        k++;
        do_read(0);
      end
      check("R5 settle length", k, SETTLE + 1);
      check("R5 freeze fall", {31'd0, frz}, 0);
    end

    // R10 sticky and clear
    do_write(4, 2);
    do_read(8); check("R10 set", got, 4);
    do_write(8, 2);
    do_read(8); check("R10 keep", got, 4);
    do_write(4, 5);
    do_read(8); check("R10 accumulate", got, 7);
    do_write(8, 1);
    do_read(8); check("R10 clear", got, 0);

    // R8 request during drain has no effect
    do_reset();
    do_write(4, 1);
    do_write(4, 1);
    do_read(8); check("R8 during drain", got, 2);
    idle(DRAIN + 2);
    do_read(0); check("R8 drain completes", got, 1);
    do_write(4, 4);
    do_write(4, 4);
    do_read(8); check("R8 during settle", got, 2);

    // R7 R8 R9 R12 sweep of every control value from both conditions
    for (int base = 0; base < 2; base++) begin
      for (int v = 0; v < 8; v++) begin
        int ill;
        int ectrl;
        int efrz;
        int erst;
        int estat;
        bit acc;
        do_reset();
        if (base == 1) begin
          do_write(4, 1);
          idle(DRAIN + 2);
        end
        ill = 0;
        if ((v & 5) == 5) ill |= 1;
        if (((v & 1) != 0 && base == 0) == 0 && ((v & 1) != 0)) ill |= 2;
        if (((v & 4) != 0) && base == 0) ill |= 2;
        if (((v & 2) != 0) && base == 0) ill |= 4;
        acc   = (ill == 0);
        ectrl = acc ? v : base;
        efrz  = (base == 1 || (acc && (v & 1) != 0)) ? 1 : 0;
        erst  = (acc && base == 1 && (v & 2) != 0 && (v & 4) == 0) ? 1 : 0;
        if (acc && base == 0 && (v & 1) != 0)      estat = 1;
        else if (acc && base == 1 && (v & 4) != 0) estat = 2;
        else                                       estat = (base == 1) ? 1 : 2;
        do_write(4, v);
        check("R8 sweep freeze", {31'd0, frz}, efrz);
        check("R9 sweep region reset", {31'd0, rrst}, erst);
        do_read(8); check("R7 R8 R9 sweep viol", got, ill);
        do_read(4); check("R12 sweep ctrl", got, ectrl);
        idle(DRAIN + SETTLE + 2);
        do_read(0); check("R6 sweep status", got, estat);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule